// File: doc/BRIEF.md
# Serial EEPROM Device Command Engine

This block behaves as the device end of a four-wire serial EEPROM that holds 16-bit words. It runs on a fast system clock and oversamples the serial clock, chip select and data-in lines. On each rising serial clock edge seen while chip select is high, it takes one bit. The bits form a start bit, a two-bit opcode, an address and, for the two write forms, sixteen data bits. The array is an ordinary register file, so the model can be synthesized or dropped into a system-level test in place of a real part.

Read, write, single-word erase, write-all, erase-all, write enable and write disable are all supported. The opcode-00 group is split by the two most significant address bits. A protection latch comes out of reset cleared. Every command that changes the array is ignored until the enable command has been received.

Top module: `serial_eeprom_model`

## Requirements
- R1: Bits are taken only while `cs` is high. While `cs` is low the command decoder returns to waiting for a start bit, and `sdo_en` is low from the next clock. A command cut short this way has no effect.
- R2: Zero bits clocked in before the first 1 are ignored. The first 1 is the start bit.
- R3: Opcode 10 is a read. After the last address bit, `sdo_en` goes high and `sdo` shows a 0. Each later rising serial clock edge then presents the next bit of the stored word, MSB first, for 16 edges.
- R4: Opcode 01 is a write. The 16 data bits follow the address, MSB first, and the word is stored after the last data bit.
- R5: Opcode 11 sets the addressed word to 16'hFFFF and leaves the other words unchanged.
- R6: Opcode 00 with top address bits 11 sets the protection latch. With top bits 00 it clears the latch. While the latch is clear, write, erase, write-all and erase-all leave the array unchanged.
- R7: Opcode 00 with top address bits 10 sets every word to 16'hFFFF.
- R8: Opcode 00 with top address bits 01 takes 16 data bits and stores them in every word.
- R9: After reset, every word reads 16'hFFFF, the protection latch is clear and `sdo_en` is low.
- R10: A write whose data phase is ended early by `cs` falling leaves the addressed word unchanged.
- R11: Whenever `sdo_en` is low, `sdo` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; oversamples the serial lines |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, active high |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data into the device |
| sdo | output | 1 | Serial read data; 0 when not driving |
| sdo_en | output | 1 | High while read data is being presented |

## Verification
A serial bit is taken on the first system clock edge at which `sck` is seen high. Any output that the bit causes appears one system clock later. The bench holds each serial clock level for two system clocks and reads `sdo` on a falling system clock edge after the serial clock has returned low. This means every read bit, including the leading 0, is sampled one full serial phase after the edge that launched it. Array effects are checked only through later read commands, so each write, erase or blocked command is judged by the word it leaves behind.

// File: rtl/serial_eeprom_model.sv
module serial_eeprom_model #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sck,
  input  logic sdi,
  output logic sdo,
  output logic sdo_en
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int MAXB  = (ADDR_W > WORD_W) ? ADDR_W : WORD_W;
  localparam int CNT_W = $clog2(MAXB + 1);

  typedef enum logic [2:0] {S_IDLE, S_OP, S_ADR, S_DAT, S_RD, S_END} st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic [1:0]        op;
  logic [ADDR_W-1:0] adr;
  logic [WORD_W-1:0] dat;
  logic [WORD_W:0]   rd_sh;
  logic              wen;
  logic              sck_q;
  logic [WORD_W-1:0] mem [DEPTH];

  wire              sck_rise = cs & sck & ~sck_q;
  wire [ADDR_W-1:0] adr_n    = {adr[ADDR_W-2:0], sdi};
  wire [WORD_W-1:0] dat_n    = {dat[WORD_W-2:0], sdi};
  wire [1:0]        sub      = adr_n[ADDR_W-1 -: 2];

  assign sdo = rd_sh[WORD_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      op     <= '0;
      adr    <= '0;
      dat    <= '0;
      rd_sh  <= '0;
      wen    <= 1'b0;
      sck_q  <= 1'b0;
      sdo_en <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else begin
      sck_q <= sck;
      if (!cs) begin
        st     <= S_IDLE;
        cnt    <= '0;
        rd_sh  <= '0;
        sdo_en <= 1'b0;
      end else if (sck_rise) begin
        case (st)
          S_IDLE: if (sdi) begin
            st  <= S_OP;
            cnt <= '0;
          end
          S_OP: begin
            op <= {op[0], sdi};
            if (cnt == CNT_W'(1)) begin
              cnt <= '0;
              st  <= S_ADR;
            end else cnt <= cnt + 1'b1;
          end
          S_ADR: begin
            adr <= adr_n;
            if (cnt == CNT_W'(ADDR_W - 1)) begin
              cnt <= '0;
              st  <= S_END;
              case (op)
                2'b10: begin
                  st     <= S_RD;
                  rd_sh  <= {1'b0, mem[adr_n]};
                  sdo_en <= 1'b1;
                end
                2'b01: st <= S_DAT;
                2'b11: if (wen) mem[adr_n] <= '1;
                default: case (sub)
                  2'b11: wen <= 1'b1;
                  2'b00: wen <= 1'b0;
                  2'b10: if (wen) for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
                  default: st <= S_DAT;
                endcase
              endcase
            end else cnt <= cnt + 1'b1;
          end
          S_DAT: begin
            dat <= dat_n;
            if (cnt == CNT_W'(WORD_W - 1)) begin
              cnt <= '0;
              st  <= S_END;
              if (wen) begin
                if (op == 2'b01) mem[adr] <= dat_n;
                else for (int i = 0; i < DEPTH; i++) mem[i] <= dat_n;
              end
            end else cnt <= cnt + 1'b1;
          end
          S_RD: rd_sh <= {rd_sh[WORD_W-1:0], 1'b0};
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_eeprom_model_chk.sv
module serial_eeprom_model_chk (
  input logic clk,
  input logic rst_n,
  input logic cs,
  input logic sck_rise,
  input logic sdo,
  input logic sdo_en,
  input logic wen
);
  assert_quiet_after_cs_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> !sdo_en);

  assert_out_zero_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_en |-> !sdo);

  assert_leading_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_en) |-> !sdo);

  assert_sdo_moves_on_sck_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_en && $past(sdo_en) && !$stable(sdo)) |-> $past(sck_rise));

  assert_latch_needs_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wen) |-> $past(cs));

  assert_reset_protected_R9: assert property (@(posedge clk)
    $rose(rst_n) |-> (!wen && !sdo_en));
endmodule

bind serial_eeprom_model serial_eeprom_model_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .sck_rise(sck_rise),
  .sdo(sdo), .sdo_en(sdo_en), .wen(wen)
);

// File: tb/tb_serial_eeprom_model.sv
module tb_serial_eeprom_model;
  localparam int AW = 6;
  localparam int N  = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sck = 1'b0, sdi = 1'b0;
  logic sdo, sdo_en;
  int checks = 0, errors = 0, cyc = 0;
  logic [15:0] exp_mem [N];

  serial_eeprom_model #(.ADDR_W(AW), .WORD_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sck(sck), .sdi(sdi),
    .sdo(sdo), .sdo_en(sdo_en));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic b);
    @(negedge clk) sdi = b; sck = 1'b1;
    repeat (2) @(negedge clk);
    sck = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic sel();
    @(negedge clk) cs = 1'b1;
    @(negedge clk);
  endtask

  task automatic desel();
    @(negedge clk) cs = 1'b0; sdi = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic header(input int zeros, input logic [1:0] op, input logic [AW-1:0] a);
    sel();
    for (int i = 0; i < zeros; i++) pulse(1'b0);
    pulse(1'b1);
    pulse(op[1]); pulse(op[0]);
    for (int i = AW - 1; i >= 0; i--) pulse(a[i]);
  endtask

  task automatic send_word(input logic [15:0] d, input int nbits);
    for (int i = 15; i > 15 - nbits; i--) pulse(d[i]);
  endtask

  task automatic cmd_sub(input int zeros, input logic [1:0] s);
    header(zeros, 2'b00, {s, {(AW-2){1'b0}}});
    desel();
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [15:0] d);
    header(0, 2'b01, a);
    send_word(d, 16);
    desel();
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [15:0] v, output bit frame_ok);
    frame_ok = 1'b1;
    header(0, 2'b10, a);
    if (!(sdo_en === 1'b1 && sdo === 1'b0)) frame_ok = 1'b0;
    v = '0;
    for (int i = 0; i < 16; i++) begin
      pulse(1'b0);
      v = {v[14:0], sdo};
      if (sdo_en !== 1'b1) frame_ok = 1'b0;
    end
    desel();
  endtask

  task automatic read_check(input logic [AW-1:0] a, input string req);
    logic [15:0] v;
    bit fok;
    do_read(a, v, fok);
    check(v === exp_mem[a], req, v, exp_mem[a]);
    check(fok, "R3 frame", {15'd0, fok}, 16'd1);
  endtask

  initial begin
    logic [15:0] pat;
    for (int i = 0; i < N; i++) exp_mem[i] = 16'hFFFF;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 R11: reset state at the ports
    check(sdo_en === 1'b0, "R9 sdo_en after reset", {15'd0, sdo_en}, 16'd0);
    check(sdo === 1'b0, "R11 sdo idle", {15'd0, sdo}, 16'd0);
    read_check(5, "R9 erased word");
    check(sdo_en === 1'b0, "R1 sdo_en after cs low", {15'd0, sdo_en}, 16'd0);

    // R6: write blocked while protected from reset
    do_write(3, 16'h1234);
    read_check(3, "R6 write while protected");

    // R2: leading zeros before start bit, then enable
    cmd_sub(3, 2'b11);
    // R4 R3: sweep every address
    for (int a = 0; a < N; a++) begin
      pat = 16'((a * 16'h9E37) ^ 16'h5A5A);
      do_write(a[AW-1:0], pat);
      exp_mem[a] = pat;
    end
    for (int a = 0; a < N; a++) read_check(a[AW-1:0], "R4 R2 write sweep");

    // R10 R1: write cut short by cs
    header(0, 2'b01, 7);
    send_word(16'h0000, 8);
    check(sdo_en === 1'b0 && sdo === 1'b0, "R11 quiet during write", {14'd0, sdo_en, sdo}, 16'd0);
    desel();
    read_check(7, "R10 truncated write");

    // R5: single erase
    header(0, 2'b11, 9); desel();
    exp_mem[9] = 16'hFFFF;
    read_check(9, "R5 erased word");
    read_check(10, "R5 neighbour kept");

    // R6: disable then try erase and write
    cmd_sub(0, 2'b00);
    header(0, 2'b11, 11); desel();
    do_write(12, 16'h0F0F);
    read_check(11, "R6 erase blocked");
    read_check(12, "R6 write blocked");
    header(0, 2'b00, {2'b10, 4'b0}); desel();
    read_check(13, "R6 erase-all blocked");

    // R8: write all
    cmd_sub(0, 2'b11);
    header(0, 2'b00, {2'b01, 4'b0});
    send_word(16'hC3A5, 16);
    desel();
    for (int i = 0; i < N; i++) exp_mem[i] = 16'hC3A5;
    for (int a = 0; a < N; a++) read_check(a[AW-1:0], "R8 write all");

    // R7: erase all
    cmd_sub(0, 2'b10);
    for (int i = 0; i < N; i++) exp_mem[i] = 16'hFFFF;
    for (int a = 0; a < N; a += 3) read_check(a[AW-1:0], "R7 erase all");

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule